// File: doc/BRIEF.md
# Host/Controller Mailbox and Software-Interrupt Register Block

This block sits between two bus ports: one used by the host and one used by the embedded controller (EC). Each side uses it to pass bytes and flags to the other. It holds two byte-wide mailboxes. The host fills one of them and the EC drains it. The EC fills the other and the host reads it. It also holds a 16-bit interrupt source word.

Bit 0 of the source word tracks unread data in the EC-to-host mailbox. Bits 1 and up are software-interrupt flags that only the EC can set. A mask programmed by the EC decides, bit by bit, whether the host may clear each flag. A flag the host cannot clear acts as sticky level status. A flag the host can clear acts as edge status.

A host write into its mailbox gives the EC a one-cycle interrupt pulse. Any pending source bit drives a host event level, gated by an EC-owned enable. The logic that carries that level to the host as a serial IRQ or an SMI lies outside this block.

Top module: `hecmb_regs`

## Requirements
- R1: After reset, both mailboxes, the source word, the host-clear mask and the event enable are zero, and `ec_irq` and `host_evt` are low.
- R2: A host write to host address 0 loads `host_wdata` into the host-to-EC mailbox. `ec_irq` is high for exactly the one cycle after the write. A host read of address 0 returns the mailbox.
- R3: An EC write to EC address 0 clears each host-to-EC mailbox bit where `ec_wdata[7:0]` holds a 1 and keeps the others. If a host write to host address 0 falls in the same cycle, the host's value is loaded.
- R4: An EC write to EC address 1 loads `ec_wdata[7:0]` into the EC-to-host mailbox and sets source bit 0. A host read of host address 1 returns the mailbox and clears source bit 0 on that edge. If both happen in the same cycle, bit 0 stays set.
- R5: An EC write to EC address 2 sets every source bit in positions 1..15 where `ec_wdata` holds a 1. Zero bits, and bit 0 of that write, have no effect.
- R6: Host address 2 reads source bits 7..0, and host address 3 reads source bits 15..8.
- R7: The host-clear mask lives at EC address 3. Its bit 0 always reads 0. A host write to address 2 (low byte) or address 3 (high byte) clears a source bit in 1..15 only where the written bit is 1 and the mask bit is 1. Source bit 0 is never cleared by a host write.
- R8: When an EC set and a host clear hit the same source bit in the same cycle, the bit ends up set.
- R9: `host_evt` is high exactly when the event enable (EC address 4, bit 0) is 1 and at least one source bit is set.
- R10: EC reads return the following. Address 0 gives the host-to-EC mailbox, zero-extended. Address 1 gives the EC-to-host mailbox, zero-extended. Address 2 gives the source word, address 3 the mask and address 4 the enable in bit 0. Addresses 5..7 read 0.
- R11: A host write to host address 1 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_re | input | 1 | Host read strobe (side effects only) |
| host_addr | input | 2 | Host register select |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, combinational |
| ec_we | input | 1 | EC write strobe |
| ec_addr | input | 3 | EC register select |
| ec_wdata | input | 16 | EC write data |
| ec_rdata | output | 16 | EC read data, combinational |
| ec_irq | output | 1 | One-cycle pulse after a host mailbox write |
| host_evt | output | 1 | Gated level: any source bit pending |

## Verification
The bench aims at same-cycle collisions. It drives an EC set with a host clear on one flag, an EC mailbox write with a host mailbox read, and a host load with an EC bit-clear. If the priority were reversed, a flag or a new value would be lost.

The bench also tries to clear flags from the host while the mask is zero, and tries to clear bit 0 through the source registers. A design that ignored the mask or let the host touch bit 0 would drop status the EC still needs. It writes to the read-only host mailbox slot and checks that nothing changes.

A behavioural reference model follows every cycle of a long random run. Any slip in the timing of the interrupt pulse or the event gating then appears as a mismatch on the first cycle it occurs.

// File: rtl/hecmb_pkg.sv
package hecmb_pkg;
   localparam int HOST_AW = 2;
   localparam int EC_AW   = 3;

   typedef enum logic [HOST_AW-1:0] {
      H_TOEC   = 2'd0,
      H_FROMEC = 2'd1,
      H_SRC_LO = 2'd2,
      H_SRC_HI = 2'd3
   } host_reg_e;

   typedef enum logic [EC_AW-1:0] {
      E_TOEC   = 3'd0,
      E_FROMEC = 3'd1,
      E_SWI    = 3'd2,
      E_HCLR   = 3'd3,
      E_EVT    = 3'd4
   } ec_reg_e;
endpackage

// File: rtl/hecmb_mbox.sv
// One mailbox register: a full load from the writing side and a
// bit-clear from the draining side. LOAD_WINS picks the collision order.
module hecmb_mbox #(
   parameter int W         = 8,
   parameter bit LOAD_WINS = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         clr,
   input  logic [W-1:0] clr_bits,
   output logic [W-1:0] q
);
   logic [W-1:0] d;

   generate
      if (LOAD_WINS) begin : g_load_first
         always_comb begin
            if (load)     d = load_val;
            else if (clr) d = q & ~clr_bits;
            else          d = q;
         end
      end else begin : g_clr_first
         always_comb begin
            if (clr)       d = q & ~clr_bits;
            else if (load) d = load_val;
            else           d = q;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
   end
endmodule

// File: rtl/hecmb_src_cell.sv
// One interrupt source flag; a set request has priority over a clear.
module hecmb_src_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= 1'b0;
      else if (set) q <= 1'b1;
      else if (clr) q <= 1'b0;
   end
endmodule

// File: rtl/hecmb_swi_bank.sv
// Interrupt source word plus the host-clear mask.
// Bit 0 is the mailbox flag. Bits 1.. are software flags that the EC sets.
module hecmb_swi_bank #(
   parameter int SRC_W  = 16,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ec_set_we,
   input  logic [SRC_W-1:0]  ec_set_bits,
   input  logic              mbox_set,
   input  logic              mbox_ack,
   input  logic              hclr_lo_we,
   input  logic              hclr_hi_we,
   input  logic [BYTE_W-1:0] hclr_byte,
   input  logic              mask_we,
   input  logic [SRC_W-1:0]  mask_wdata,
   output logic [SRC_W-1:0]  src,
   output logic [SRC_W-1:0]  mask
);
   for (genvar i = 0; i < SRC_W; i++) begin : g_bit
      if (i == 0) begin : g_mbox_flag
         assign mask[i] = 1'b0;
         hecmb_src_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (mbox_set),
            .clr   (mbox_ack),
            .q     (src[i])
         );
      end else begin : g_swi_flag
         logic mask_q;
         logic hclr;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       mask_q <= 1'b0;
            else if (mask_we) mask_q <= mask_wdata[i];
         end
         assign mask[i] = mask_q;

         if (i < BYTE_W) begin : g_lo
            assign hclr = hclr_lo_we & hclr_byte[i];
         end else begin : g_hi
            assign hclr = hclr_hi_we & hclr_byte[i-BYTE_W];
         end

         hecmb_src_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (ec_set_we & ec_set_bits[i]),
            .clr   (hclr & mask_q),
            .q     (src[i])
         );
      end
   end
endmodule

// File: rtl/hecmb_regs.sv
module hecmb_regs
   import hecmb_pkg::*;
#(
   parameter int MBOX_W = 8,
   parameter int SRC_W  = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               host_we,
   input  logic               host_re,
   input  logic [HOST_AW-1:0] host_addr,
   input  logic [MBOX_W-1:0]  host_wdata,
   output logic [MBOX_W-1:0]  host_rdata,
   input  logic               ec_we,
   input  logic [EC_AW-1:0]   ec_addr,
   input  logic [SRC_W-1:0]   ec_wdata,
   output logic [SRC_W-1:0]   ec_rdata,
   output logic               ec_irq,
   output logic               host_evt
);
   localparam int PAD_W = SRC_W - MBOX_W;

   generate
      if (SRC_W != 2 * MBOX_W) begin : g_bad_width
         $error("hecmb_regs: SRC_W must be twice MBOX_W");
      end
      if (MBOX_W < 2) begin : g_bad_mbox
         $error("hecmb_regs: MBOX_W must be at least 2");
      end
   endgenerate

   logic [MBOX_W-1:0] toec_q;
   logic [MBOX_W-1:0] fromec_q;
   logic [SRC_W-1:0]  src_q;
   logic [SRC_W-1:0]  mask_q;
   logic              evt_en_q;
   logic              irq_q;

   logic h_wr_toec, h_rd_fromec, h_wr_lo, h_wr_hi;
   logic e_wr_toec, e_wr_fromec, e_wr_swi, e_wr_hclr, e_wr_evt;

   assign h_wr_toec   = host_we && (host_addr == H_TOEC);
   assign h_rd_fromec = host_re && (host_addr == H_FROMEC);
   assign h_wr_lo     = host_we && (host_addr == H_SRC_LO);
   assign h_wr_hi     = host_we && (host_addr == H_SRC_HI);
   assign e_wr_toec   = ec_we && (ec_addr == E_TOEC);
   assign e_wr_fromec = ec_we && (ec_addr == E_FROMEC);
   assign e_wr_swi    = ec_we && (ec_addr == E_SWI);
   assign e_wr_hclr   = ec_we && (ec_addr == E_HCLR);
   assign e_wr_evt    = ec_we && (ec_addr == E_EVT);

   hecmb_mbox #(.W(MBOX_W), .LOAD_WINS(1'b1)) u_toec (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (h_wr_toec),
      .load_val (host_wdata),
      .clr      (e_wr_toec),
      .clr_bits (ec_wdata[MBOX_W-1:0]),
      .q        (toec_q)
   );

   hecmb_mbox #(.W(MBOX_W), .LOAD_WINS(1'b1)) u_fromec (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (e_wr_fromec),
      .load_val (ec_wdata[MBOX_W-1:0]),
      .clr      (1'b0),
      .clr_bits ('0),
      .q        (fromec_q)
   );

   hecmb_swi_bank #(.SRC_W(SRC_W), .BYTE_W(MBOX_W)) u_swi (
      .clk         (clk),
      .rst_n       (rst_n),
      .ec_set_we   (e_wr_swi),
      .ec_set_bits (ec_wdata),
      .mbox_set    (e_wr_fromec),
      .mbox_ack    (h_rd_fromec),
      .hclr_lo_we  (h_wr_lo),
      .hclr_hi_we  (h_wr_hi),
      .hclr_byte   (host_wdata),
      .mask_we     (e_wr_hclr),
      .mask_wdata  (ec_wdata),
      .src         (src_q),
      .mask        (mask_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         evt_en_q <= 1'b0;
         irq_q    <= 1'b0;
      end else begin
         irq_q <= h_wr_toec;
         if (e_wr_evt) evt_en_q <= ec_wdata[0];
      end
   end

   assign ec_irq   = irq_q;
   assign host_evt = evt_en_q & (|src_q);

   always_comb begin
      unique case (host_addr)
         H_TOEC:   host_rdata = toec_q;
         H_FROMEC: host_rdata = fromec_q;
         H_SRC_LO: host_rdata = src_q[MBOX_W-1:0];
         default:  host_rdata = src_q[SRC_W-1:MBOX_W];
      endcase
   end

   always_comb begin
      case (ec_addr)
         E_TOEC:   ec_rdata = {{PAD_W{1'b0}}, toec_q};
         E_FROMEC: ec_rdata = {{PAD_W{1'b0}}, fromec_q};
         E_SWI:    ec_rdata = src_q;
         E_HCLR:   ec_rdata = mask_q;
         E_EVT:    ec_rdata = {{(SRC_W-1){1'b0}}, evt_en_q};
         default:  ec_rdata = '0;
      endcase
   end
endmodule

// File: rtl/hecmb_regs_chk.sv
module hecmb_regs_chk
   import hecmb_pkg::*;
#(
   parameter int MBOX_W = 8,
   parameter int SRC_W  = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               host_we,
   input logic [HOST_AW-1:0] host_addr,
   input logic               ec_we,
   input logic [EC_AW-1:0]   ec_addr,
   input logic [SRC_W-1:0]   ec_wdata,
   input logic               ec_irq,
   input logic               host_evt,
   input logic [MBOX_W-1:0]  toec_q,
   input logic [SRC_W-1:0]   src_q,
   input logic [SRC_W-1:0]   mask_q,
   input logic               evt_en_q
);
   localparam logic [SRC_W-1:0] SWI_BITS = ~{{(SRC_W-1){1'b0}}, 1'b1};

   assert_irq_follows_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (host_we && host_addr == H_TOEC) |=> ec_irq);

   assert_irq_has_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ec_irq |-> $past(host_we && host_addr == H_TOEC));

   assert_toec_bits_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ec_we && ec_addr == E_TOEC && !(host_we && host_addr == H_TOEC))
      |=> ((toec_q & $past(ec_wdata[MBOX_W-1:0])) == '0));

   assert_mbox_flag_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ec_we && ec_addr == E_FROMEC) |=> src_q[0]);

   // also covers R8: a set lands even when the host clears in the same cycle
   assert_swi_set_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ec_we && ec_addr == E_SWI)
      |=> ((src_q & $past(ec_wdata) & SWI_BITS) == ($past(ec_wdata) & SWI_BITS)));

   assert_unmasked_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(src_q) & ~$past(mask_q) & ~src_q & SWI_BITS) == '0));

   assert_evt_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !evt_en_q |-> !host_evt);
endmodule

bind hecmb_regs hecmb_regs_chk #(.MBOX_W(MBOX_W), .SRC_W(SRC_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .host_we   (host_we),
   .host_addr (host_addr),
   .ec_we     (ec_we),
   .ec_addr   (ec_addr),
   .ec_wdata  (ec_wdata),
   .ec_irq    (ec_irq),
   .host_evt  (host_evt),
   .toec_q    (toec_q),
   .src_q     (src_q),
   .mask_q    (mask_q),
   .evt_en_q  (evt_en_q)
);

// File: tb/hecmb_regs_tb_top.sv
`timescale 1ns/100ps
module hecmb_regs_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_we = 0, host_re = 0;
   logic [1:0]  host_addr = 0;
   logic [7:0]  host_wdata = 0;
   logic [7:0]  host_rdata;
   logic        ec_we = 0;
   logic [2:0]  ec_addr = 0;
   logic [15:0] ec_wdata = 0;
   logic [15:0] ec_rdata;
   logic        ec_irq, host_evt;

   int checks = 0;
   int errors = 0;
   bit live = 0;

   always #2.5 clk = ~clk;

   hecmb_regs dut_i (
      .clk(clk), .rst_n(rst_n),
      .host_we(host_we), .host_re(host_re), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata),
      .ec_we(ec_we), .ec_addr(ec_addr), .ec_wdata(ec_wdata), .ec_rdata(ec_rdata),
      .ec_irq(ec_irq), .host_evt(host_evt)
   );

   // behavioural reference model
   int m_toec = 0, m_fromec = 0, m_src = 0, m_mask = 0, m_evt = 0, m_irq = 0;

   always @(posedge clk) begin
      int set_b, clr_b;
      if (!rst_n) begin
         m_toec = 0; m_fromec = 0; m_src = 0; m_mask = 0; m_evt = 0; m_irq = 0;
      end else begin
         m_irq = (host_we && host_addr == 0) ? 1 : 0;
         if (host_we && host_addr == 0)   m_toec = host_wdata;
         else if (ec_we && ec_addr == 0)  m_toec = m_toec & ~int'(ec_wdata[7:0]);
         if (ec_we && ec_addr == 1)       m_fromec = ec_wdata[7:0];
         set_b = 0; clr_b = 0;
         if (ec_we && ec_addr == 2) set_b = ec_wdata & 16'hFFFE;
         if (ec_we && ec_addr == 1) set_b = set_b | 1;
         if (host_we && host_addr == 2) clr_b = clr_b | host_wdata;
         if (host_we && host_addr == 3) clr_b = clr_b | (int'(host_wdata) << 8);
         clr_b = clr_b & m_mask;
         if (host_re && host_addr == 1) clr_b = clr_b | 1;
         m_src = ((m_src & ~clr_b) | set_b) & 16'hFFFF;
         if (ec_we && ec_addr == 3) m_mask = ec_wdata & 16'hFFFE;
         if (ec_we && ec_addr == 4) m_evt = ec_wdata[0];
      end
   end

   function automatic int m_host_rd(int a);
      case (a)
         0: return m_toec;
         1: return m_fromec;
         2: return m_src & 8'hFF;
         default: return (m_src >> 8) & 8'hFF;
      endcase
   endfunction

   function automatic int m_ec_rd(int a);
      case (a)
         0: return m_toec;
         1: return m_fromec;
         2: return m_src;
         3: return m_mask;
         4: return m_evt;
         default: return 0;
      endcase
   endfunction

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always begin
      @(negedge clk);
      #1;
      if (live) begin
         chk("R2 ec_irq", ec_irq, m_irq);
         chk("R9 host_evt", host_evt, (m_evt != 0 && m_src != 0) ? 1 : 0);
         case (host_addr)
            0: chk("R2 host_rdata", host_rdata, m_host_rd(0));
            1: chk("R4 host_rdata", host_rdata, m_host_rd(1));
            default: chk("R6 host_rdata", host_rdata, m_host_rd(host_addr));
         endcase
         chk("R10 ec_rdata", ec_rdata, m_ec_rd(ec_addr));
      end
   end

   // drive one cycle at the falling edge, then settle
   task automatic cyc(bit hwe, bit hre, int ha, int hd, bit ewe, int ea, int ed);
      @(negedge clk);
      host_we = hwe; host_re = hre; host_addr = ha[1:0]; host_wdata = hd[7:0];
      ec_we = ewe; ec_addr = ea[2:0]; ec_wdata = ed[15:0];
      #1;
   endtask

   task automatic ec_rd(int a);  cyc(0, 0, 0, 0, 0, a, 0); endtask
   task automatic host_rd(int a); cyc(0, 1, a, 0, 0, 7, 0); endtask
   task automatic host_wr(int a, int d); cyc(1, 0, a, d, 0, 7, 0); endtask
   task automatic ec_wr(int a, int d); cyc(0, 0, 0, 0, 1, a, d); endtask

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      live = 1;
      // R1: reset state
      for (int a = 0; a < 5; a++) begin
         ec_rd(a);
         chk("R1 reset ec reg", ec_rdata, 0);
      end
      chk("R1 reset irq", ec_irq, 0);
      chk("R1 reset evt", host_evt, 0);

      // R2: host mailbox load and interrupt pulse
      host_wr(0, 8'hA5);
      host_rd(0);
      chk("R2 irq pulse", ec_irq, 1);
      chk("R2 mailbox", host_rdata, 8'hA5);
      ec_rd(0);
      chk("R2 irq single cycle", ec_irq, 0);

      // R3: EC bit-clear and collision with host load
      ec_wr(0, 16'h0021);
      ec_rd(0);
      chk("R3 w1c", ec_rdata, 8'h84);
      cyc(1, 0, 0, 8'h3C, 1, 0, 16'h00FF);
      ec_rd(0);
      chk("R3 host load wins", ec_rdata, 8'h3C);

      // R4: EC mailbox and flag bit 0
      ec_wr(1, 16'h005A);
      ec_rd(2);
      chk("R4 flag set", ec_rdata, 16'h0001);
      host_rd(1);
      chk("R4 host reads mailbox", host_rdata, 8'h5A);
      ec_rd(2);
      chk("R4 flag cleared by read", ec_rdata, 16'h0000);
      cyc(0, 1, 1, 0, 1, 1, 16'h0033);
      ec_rd(2);
      chk("R4 set beats read clear", ec_rdata, 16'h0001);
      host_rd(1);

      // R5: software set
      ec_wr(2, 16'h8003);
      ec_rd(2);
      chk("R5 w1s skips bit0", ec_rdata, 16'h8002);
      ec_wr(2, 16'h0000);
      ec_rd(2);
      chk("R5 zero write no effect", ec_rdata, 16'h8002);

      // R6: host byte view
      host_rd(2);
      chk("R6 low byte", host_rdata, 8'h02);
      host_rd(3);
      chk("R6 high byte", host_rdata, 8'h80);

      // R7: mask gating
      host_wr(3, 8'h80);
      ec_rd(2);
      chk("R7 mask zero blocks clear", ec_rdata, 16'h8002);
      ec_wr(3, 16'hFFFF);
      ec_rd(3);
      chk("R7 mask bit0 reads zero", ec_rdata, 16'hFFFE);
      host_wr(3, 8'h80);
      ec_rd(2);
      chk("R7 masked clear", ec_rdata, 16'h0002);
      ec_wr(1, 16'h0011);
      host_wr(2, 8'h01);
      ec_rd(2);
      chk("R7 bit0 not host clearable", ec_rdata, 16'h0003);

      // R8: set wins over clear
      cyc(1, 0, 2, 8'h04, 1, 2, 16'h0004);
      ec_rd(2);
      chk("R8 set wins", ec_rdata, 16'h0007);
      host_wr(2, 8'h06);
      ec_rd(2);
      chk("R8 later clear", ec_rdata, 16'h0001);

      // R9: event gating
      chk("R9 evt disabled", host_evt, 0);
      ec_wr(4, 1);
      ec_rd(4);
      chk("R9 evt enabled", host_evt, 1);
      host_rd(1);
      ec_rd(2);
      chk("R9 evt drops when empty", host_evt, 0);

      // R10: unmapped EC addresses
      for (int a = 5; a < 8; a++) begin
         ec_rd(a);
         chk("R10 unmapped", ec_rdata, 0);
      end

      // R11: host write to read-only slot
      host_wr(1, 8'hEE);
      ec_rd(1);
      chk("R11 ignored", ec_rdata, 8'h11);
      ec_rd(2);
      chk("R11 src unchanged", ec_rdata, 16'h0000);

      // random traffic against the model
      for (int n = 0; n < 3000; n++) begin
         cyc($urandom_range(0, 2) == 0, $urandom_range(0, 3) == 0, $urandom_range(0, 3),
             $urandom_range(0, 255), $urandom_range(0, 2) == 0, $urandom_range(0, 5),
             $urandom_range(0, 65535));
      end
      cyc(0, 0, 0, 0, 0, 0, 0);
      @(negedge clk); #2;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule